// File: doc/BRIEF.md
# Latent-Read Parallel I/O Port

This block sits between a processor core and an external parallel bus that is shared by eight logical ports. The core reads through a single on-chip input register. A read returns that register's contents in the same cycle. The same read then starts an external fetch on the logical port it addresses. When the external device signals ready, the fetched word replaces the register contents. Each read therefore delivers the word brought in by the read before it, and the next read collects the word it fetches.

Writes go through a separate output register. A write drives the addressed port number and holds an active-low write strobe for a fixed number of cycles. Writes never affect the input register. Only one external transaction runs at a time. A core access issued while a transaction runs is held off with a wait output until the bus is free.

Reading a block of N words takes N+1 reads. The first read returns stale data. The last read starts one extra fetch, and that fetch overwrites the final word held in the register.

Top module: `lpio_port`

## Requirements
- R1: `cpu_rdata` always equals the input register. In the cycle a read is accepted, it shows the word held before that read, with no added latency.
- R2: A read is accepted when `cpu_rd` is high while `busy` is low. In the next cycle `ext_rd_n` is 0, `ext_addr` equals the port number that was read, and `busy` is 1.
- R3: `ext_rd_n` stays low, with `ext_addr` unchanged, until a cycle in which `ext_rdy` is 1. `ext_din` is sampled in that cycle. In the following cycle the input register holds that word, `ext_rd_n` is 1 and `busy` is 0.
- R4: The value returned by any read is the word fetched by the previous read, from the port that the previous read addressed, whatever port the current read names.
- R5: While `busy` is 1, a raised `cpu_rd` or `cpu_wr` sets `cpu_wait` to 1 and is not accepted. It is accepted in the first cycle `busy` is 0.
- R6: A write is accepted when `cpu_wr` is high, `cpu_rd` is low and `busy` is low. From the next cycle, `ext_dout` shows `cpu_wdata`, `ext_addr` shows the port, and `ext_wr_n` is 0 for exactly WR_PULSE cycles (default 2). The two strobes are never low together.
- R7: Writes never change the input register.
- R8: Reads never change the output register, so `ext_dout` is unchanged by a read.
- R9: During and right after reset, both registers are zero, `ext_rd_n` and `ext_wr_n` are 1, and `busy` and `cpu_wait` are 0.
- R10: When `cpu_rd` and `cpu_wr` are high together on an idle port, the read is performed and the write is discarded. No write strobe follows and `ext_dout` keeps its value.
- R11: `ext_rdy` has no effect unless a read strobe is active. The input register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Core read request |
| cpu_wr | input | 1 | Core write request |
| cpu_port | input | ADDR_W | Logical port of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Input register contents |
| cpu_wait | output | 1 | Request stalled by a running transaction |
| busy | output | 1 | External transaction in progress |
| ext_addr | output | ADDR_W | Port number on the external bus |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_rdy | input | 1 | External ready, ends a read |
| ext_din | input | DATA_W | Data from the external bus |
| ext_dout | output | DATA_W | Output register contents |

## Verification
Timing differs by result:
- `cpu_rdata` and `cpu_wait` are combinational, so they are checked in the same cycle as the request.
- The read strobe, the address and `busy` come one clock edge after a request is accepted.
- A fetched word appears one edge after the cycle in which ready was high.
- The write strobe covers the WR_PULSE cycles that follow acceptance.

The bench drives inputs and samples outputs on the falling clock edge. It checks each result in the exact cycle counted above. It keeps its own model of the last fetched word and of per-port data sequences, so every read can be compared against the previous read's fetch.

// File: rtl/lpio_pkg.sv
package lpio_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_READ = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/lpio_seq.sv
module lpio_seq
    import lpio_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int WR_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_port,
    input  logic              ext_rdy,
    output logic              busy,
    output logic              cpu_wait,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic              load_in,
    output logic              load_out
);

    localparam int CNT_W = (WR_PULSE > 1) ? $clog2(WR_PULSE) : 1;

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            SEQ_IDLE: begin
                if (cpu_rd) begin
                    s_d.state = SEQ_READ;
                    s_d.addr  = cpu_port;
                end else if (cpu_wr) begin
                    s_d.state = SEQ_WRITE;
                    s_d.addr  = cpu_port;
                    s_d.cnt   = CNT_W'(WR_PULSE - 1);
                end
            end
            SEQ_READ: begin
                if (ext_rdy) begin
                    s_d.state = SEQ_IDLE;
                end
            end
            SEQ_WRITE: begin
                if (s_q.cnt == '0) begin
                    s_d.state = SEQ_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{state: SEQ_IDLE, addr: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.state != SEQ_IDLE);
    assign cpu_wait = busy && (cpu_rd || cpu_wr);
    assign ext_addr = s_q.addr;
    assign ext_rd_n = (s_q.state != SEQ_READ);
    assign ext_wr_n = (s_q.state != SEQ_WRITE);
    assign load_in  = (s_q.state == SEQ_READ) && ext_rdy;
    assign load_out = (s_q.state == SEQ_IDLE) && cpu_wr && !cpu_rd;

endmodule

// File: rtl/lpio_regs.sv
module lpio_regs #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_in,
    input  logic [DATA_W-1:0] ext_din,
    input  logic              load_out,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] in_word,
    output logic [DATA_W-1:0] out_word
);

    typedef struct packed {
        logic [DATA_W-1:0] in_reg;
        logic [DATA_W-1:0] out_reg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_in) begin
            r_d.in_reg = ext_din;
        end
        if (load_out) begin
            r_d.out_reg = cpu_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_word  = r_q.in_reg;
    assign out_word = r_q.out_reg;

endmodule

// File: rtl/lpio_port.sv
module lpio_port #(
    parameter int DATA_W   = 16,
    parameter int PORTS    = 8,
    parameter int WR_PULSE = 2,
    localparam int ADDR_W  = $clog2(PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_port,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_wait,
    output logic              busy,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    input  logic              ext_rdy,
    input  logic [DATA_W-1:0] ext_din,
    output logic [DATA_W-1:0] ext_dout
);

    logic load_in;
    logic load_out;

    lpio_seq #(
        .ADDR_W  (ADDR_W),
        .WR_PULSE(WR_PULSE)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_rd  (cpu_rd),
        .cpu_wr  (cpu_wr),
        .cpu_port(cpu_port),
        .ext_rdy (ext_rdy),
        .busy    (busy),
        .cpu_wait(cpu_wait),
        .ext_addr(ext_addr),
        .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n),
        .load_in (load_in),
        .load_out(load_out)
    );

    lpio_regs #(
        .DATA_W(DATA_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_in  (load_in),
        .ext_din  (ext_din),
        .load_out (load_out),
        .cpu_wdata(cpu_wdata),
        .in_word  (cpu_rdata),
        .out_word (ext_dout)
    );

endmodule

// File: rtl/lpio_port_chk.sv
module lpio_port_chk #(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 3,
    parameter int WR_PULSE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rd,
    input logic [ADDR_W-1:0] cpu_port,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              busy,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ext_rd_n,
    input logic              ext_wr_n,
    input logic              ext_rdy,
    input logic [DATA_W-1:0] ext_din,
    input logic [DATA_W-1:0] ext_dout
);

    localparam int CW = $clog2(WR_PULSE + 2);

    logic [CW-1:0] wr_low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_low_cnt <= '0;
        end else if (!ext_wr_n) begin
            wr_low_cnt <= wr_low_cnt + 1'b1;
        end else begin
            wr_low_cnt <= '0;
        end
    end

    // R2
    rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !busy) |=> (!ext_rd_n && busy && ext_addr == $past(cpu_port)));

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n && !ext_rdy) |=> (!ext_rd_n && $stable(ext_addr)));

    // R3
    rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n && ext_rdy) |=> (ext_rd_n && !busy && cpu_rdata == $past(ext_din)));

    // R5
    busy_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ext_dout));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    // R6
    wr_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr_n |-> (wr_low_cnt < CW'(WR_PULSE)));

    // R6
    wr_len_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_wr_n) |-> (wr_low_cnt == CW'(WR_PULSE)));

    // R7
    wr_keeps_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr_n |=> $stable(cpu_rdata));

    // R8
    rd_keeps_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rd_n |=> $stable(ext_dout));

endmodule

bind lpio_port lpio_port_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .WR_PULSE(WR_PULSE)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_rd   (cpu_rd),
    .cpu_port (cpu_port),
    .cpu_rdata(cpu_rdata),
    .busy     (busy),
    .ext_addr (ext_addr),
    .ext_rd_n (ext_rd_n),
    .ext_wr_n (ext_wr_n),
    .ext_rdy  (ext_rdy),
    .ext_din  (ext_din),
    .ext_dout (ext_dout)
);

// File: tb/lpio_port_tb_top.sv
`timescale 1ns/1ps
module lpio_port_tb_top;

    localparam int DW = 16;
    localparam int AW = 3;
    localparam int WP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [AW-1:0] cpu_port = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_wait;
    logic          busy;
    logic [AW-1:0] ext_addr;
    logic          ext_rd_n;
    logic          ext_wr_n;
    logic          ext_rdy = 1'b0;
    logic [DW-1:0] ext_din = '0;
    logic [DW-1:0] ext_dout;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [DW-1:0] exp_in = '0;
    logic [DW-1:0] exp_out = '0;
    int seq_cnt [8];

    always #2.5 clk = ~clk;

    lpio_port #(.DATA_W(DW), .PORTS(8), .WR_PULSE(WP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_port(cpu_port), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_wait(cpu_wait), .busy(busy), .ext_addr(ext_addr),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_rdy(ext_rdy),
        .ext_din(ext_din), .ext_dout(ext_dout)
    );

    function automatic logic [DW-1:0] port_word(int p, int n);
        return DW'((p << 12) | ((n * 37 + p * 5 + 1) & 12'hFFF));
    endfunction

    task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One read: returns previous fetch, then runs the external fetch with d wait cycles.
    task automatic do_read(int p, int d, bit with_wr);
        logic [DW-1:0] w;
        @(negedge clk);
        cpu_rd = 1'b1;
        cpu_port = AW'(p);
        cpu_wr = with_wr;
        cpu_wdata = 16'hDEAD;
        #0.1;
        check(cpu_rdata == exp_in, "R1/R4 read returns previous fetch", cpu_rdata, exp_in);
        check(cpu_wait == 1'b0, "R5 no wait when idle", DW'(cpu_wait), 16'd0);
        @(negedge clk);
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
        check(ext_rd_n == 1'b0 && busy == 1'b1, "R2 read strobe and busy", DW'({ext_rd_n, busy}), 16'd1);
        check(ext_addr == AW'(p), "R2 read port address", DW'(ext_addr), DW'(p));
        for (int i = 0; i < d; i++) begin
            check(ext_rd_n == 1'b0 && ext_addr == AW'(p), "R3 strobe held until ready", DW'(ext_rd_n), 16'd0);
            @(negedge clk);
        end
        w = port_word(p, seq_cnt[p]);
        seq_cnt[p]++;
        ext_rdy = 1'b1;
        ext_din = w;
        @(negedge clk);
        ext_rdy = 1'b0;
        ext_din = 16'h5A5A;
        check(ext_rd_n == 1'b1 && busy == 1'b0, "R3 strobe released", DW'({ext_rd_n, busy}), 16'd2);
        check(cpu_rdata == w, "R3 fetched word loaded", cpu_rdata, w);
        check(ext_dout == exp_out, with_wr ? "R10 simultaneous write discarded" : "R8 read keeps output", ext_dout, exp_out);
        exp_in = w;
    endtask

    task automatic do_write(int p, logic [DW-1:0] v);
        @(negedge clk);
        cpu_wr = 1'b1;
        cpu_port = AW'(p);
        cpu_wdata = v;
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_wdata = 16'h0BAD;
        for (int i = 0; i < WP; i++) begin
            check(ext_wr_n == 1'b0 && ext_rd_n == 1'b1, "R6 write strobe low", DW'(ext_wr_n), 16'd0);
            check(ext_dout == v && ext_addr == AW'(p), "R6 write data and port", ext_dout, v);
            check(cpu_rdata == exp_in, "R7 write keeps input", cpu_rdata, exp_in);
            @(negedge clk);
        end
        check(ext_wr_n == 1'b1 && busy == 1'b0, "R6 write strobe width", DW'(ext_wr_n), 16'd1);
        exp_out = v;
    endtask

    initial begin
        void'($urandom(32'd1617));
        for (int i = 0; i < 8; i++) seq_cnt[i] = 0;
        repeat (3) @(negedge clk);
        check(cpu_rdata == '0 && ext_dout == '0, "R9 registers cleared", cpu_rdata, 16'd0);
        check(ext_rd_n && ext_wr_n && !busy && !cpu_wait, "R9 strobes idle", DW'({ext_rd_n, ext_wr_n, busy, cpu_wait}), 16'hC);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_rdata == '0 && !busy, "R9 state after reset", cpu_rdata, 16'd0);

        // Vector of four words from port 3: five reads, first stale (R4)
        for (int i = 0; i < 5; i++) do_read(3, i % 2, 1'b0);

        // Alternating ports: each read returns previous port's word (R4)
        do_read(1, 0, 1'b0);
        do_read(6, 2, 1'b0);
        do_read(0, 1, 1'b0);

        do_write(5, 16'hA5C3);
        do_write(7, 16'h1234);

        // R10: read and write together
        do_read(2, 1, 1'b1);
        check(ext_dout == 16'h1234, "R10 output unchanged", ext_dout, 16'h1234);

        // R11: ready with no strobe
        @(negedge clk);
        ext_rdy = 1'b1;
        ext_din = 16'hFFFF;
        @(negedge clk);
        ext_rdy = 1'b0;
        @(negedge clk);
        check(cpu_rdata == exp_in && !busy, "R11 stray ready ignored", cpu_rdata, exp_in);

        // R5: write issued while a read is busy
        begin
            logic [DW-1:0] w;
            @(negedge clk);
            cpu_rd = 1'b1;
            cpu_port = 3'd4;
            @(negedge clk);
            cpu_rd = 1'b0;
            cpu_wr = 1'b1;
            cpu_port = 3'd1;
            cpu_wdata = 16'h7E57;
            #0.1;
            check(cpu_wait == 1'b1, "R5 wait while busy", DW'(cpu_wait), 16'd1);
            @(negedge clk);
            check(ext_wr_n == 1'b1 && ext_addr == 3'd4, "R5 write not accepted while busy", DW'(ext_wr_n), 16'd1);
            w = port_word(4, seq_cnt[4]);
            seq_cnt[4]++;
            ext_rdy = 1'b1;
            ext_din = w;
            @(negedge clk);
            ext_rdy = 1'b0;
            #0.1;
            check(cpu_wait == 1'b0 && cpu_rdata == w, "R5 wait drops when idle", cpu_rdata, w);
            exp_in = w;
            @(negedge clk);
            cpu_wr = 1'b0;
            check(ext_wr_n == 1'b0 && ext_dout == 16'h7E57, "R5 stalled write accepted", ext_dout, 16'h7E57);
            exp_out = 16'h7E57;
            repeat (WP) @(negedge clk);
            check(ext_wr_n == 1'b1 && cpu_rdata == exp_in, "R7 input kept after write", cpu_rdata, exp_in);
        end

        // Random mix
        for (int k = 0; k < 60; k++) begin
            int p;
            p = int'($urandom_range(7, 0));
            if ($urandom_range(3, 0) == 0) do_write(p, DW'($urandom));
            else do_read(p, int'($urandom_range(3, 0)), 1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule